// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The block merges four reset causes into one CPU reset: a core power-on reset, a fine (precision) power-on reset, an external pin reset and a watchdog request. All sequencing runs on a slow clock of roughly 32 kHz. After the winning cause goes away, the block keeps the reset asserted for a further number of slow cycles that depends on the cause. It then releases the CPU reset through a synchroniser into the CPU clock domain.

It also drives the main oscillator enable. The oscillator stays off during power-on and pin resets and stays running during a watchdog reset. The block keeps sticky cause flags that the CPU reset does not clear. It raises a clear strobe for the trim register on every cause except the fine power-on reset. All source inputs are synchronous to the slow clock. `rst_ni` is the block's own power-up reset; it leaves the sequencer in the core power-on state.

Top module: `reset_sequencer`

## Requirements
- R1: Active sources are ranked core power-on first, then fine power-on, then pin, then watchdog. Both the release delay and the flag updates follow the highest-ranked active source.
- R2: After the core power-on input is first seen low on a slow edge, the release takes effect on the 513th slow edge counted from that edge (a 512-cycle delay).
- R3: The fine power-on reset is stretched by one slow cycle beyond its input and then delayed by one more cycle, so the release falls on the 3rd slow edge after the input is first seen low. `trim_clr_o` stays low during this reset.
- R4: After the pin reset is first seen low, the release falls on the 9th slow edge (an 8-cycle delay).
- R5: A rising edge on `wdog_i` causes a reset that lasts exactly one slow cycle, followed by a 1-cycle delay, so the release falls on the 3rd slow edge after the rise is sampled. Holding `wdog_i` high causes no further reset.
- R6: A power-on or pin reset sets `stat_por_o` and clears both `stat_wdog_o` and `stat_ram_off_o`.
- R7: A watchdog reset clears `stat_por_o` and sets `stat_wdog_o`, and it leaves `stat_ram_off_o` unchanged. Outside reset, `ram_off_set_i` sampled high sets `stat_ram_off_o`.
- R8: `osc_en_o` is low on the slow edge after a power-on or pin source is sampled active, and stays high during a watchdog reset. It is high for at least one full slow cycle before the slow-domain release.
- R9: `cpu_rst_o` asserts asynchronously as soon as the slow-domain reset request rises. It deasserts on the second CPU clock rising edge after the request falls.
- R10: A source that arrives while a delay count is running restarts the count with that source's own delay.
- R11: `trim_clr_o` is high for the whole of a core power-on, pin or watchdog reset, including its delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow sequencing clock |
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Block power-up reset, active low, asynchronous |
| core_por_i | input | 1 | Core power-on reset request |
| fine_por_i | input | 1 | Fine power-on reset request |
| pin_rst_i | input | 1 | External pin reset request |
| wdog_i | input | 1 | Watchdog request, rising edge acts |
| ram_off_set_i | input | 1 | Sets the RAM-disable flag |
| cpu_rst_o | output | 1 | CPU reset, CPU clock domain |
| osc_en_o | output | 1 | Main oscillator enable |
| trim_clr_o | output | 1 | Clear strobe for the trim register |
| stat_por_o | output | 1 | Sticky power-on cause flag |
| stat_wdog_o | output | 1 | Sticky watchdog cause flag |
| stat_ram_off_o | output | 1 | Sticky RAM-disable flag |

## Verification
The bench counts slow edges from each source's fall to the CPU release, per source. An off-by-one in a delay, or a missing stretch on the fine power-on reset, shows up as a wrong edge count. A pin and a fine power-on reset are dropped together: a wrong priority shows as 9 edges instead of 3, and as a trim clear that should have been suppressed. A watchdog request injected mid-count has to give the short delay, and a counter that ignores the restart releases late. Holding the watchdog high must not retrigger the reset. The RAM-disable flag must survive a watchdog reset. The CPU release is timed to the exact CPU edge, which exposes a missing or extra synchroniser stage.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  // index order is also priority order, lowest index wins
  typedef enum logic [1:0] {
    SRC_CORE_POR = 2'd0,
    SRC_FINE_POR = 2'd1,
    SRC_PIN      = 2'd2,
    SRC_WDOG     = 2'd3
  } src_t;
  localparam int NUM_SRC = 4;
endpackage

// File: rtl/rstseq_src_cond.sv
module rstseq_src_cond
  import rstseq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               core_por_i,
  input  logic               fine_por_i,
  input  logic               pin_rst_i,
  input  logic               wdog_i,
  output logic [NUM_SRC-1:0] req_o
);
  logic fine_d, wdog_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_d <= 1'b0;
      wdog_d <= 1'b1;
    end else begin
      fine_d <= fine_por_i;
      wdog_d <= wdog_i;
    end
  end

  always_comb begin
    req_o = '0;
    req_o[SRC_CORE_POR] = core_por_i;
    req_o[SRC_FINE_POR] = fine_por_i | fine_d;  // one-cycle stretch
    req_o[SRC_PIN]      = pin_rst_i;
    req_o[SRC_WDOG]     = wdog_i & ~wdog_d;     // single-cycle pulse
  end
endmodule

// File: rtl/rstseq_arbiter.sv
module rstseq_arbiter
  import rstseq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic               act_o,
  output src_t               sel_o
);
  always_comb begin
    logic [1:0] idx;
    act_o = |req_i;
    idx   = 2'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx = 2'(i);
    end
    sel_o = src_t'(idx);
  end
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
  import rstseq_pkg::*;
#(
  parameter int CORE_DLY = 512,
  parameter int FINE_DLY = 1,
  parameter int PIN_DLY  = 8,
  parameter int WDOG_DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  src_t sel_i,
  output logic rst_req_o,
  output logic osc_en_o,
  output logic trim_clr_o
);
  localparam int MAX_AB = (CORE_DLY > FINE_DLY) ? CORE_DLY : FINE_DLY;
  localparam int MAX_CD = (PIN_DLY > WDOG_DLY) ? PIN_DLY : WDOG_DLY;
  localparam int MAX_D  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAX_D + 1);

  logic [CW-1:0] cnt_q, load_val;
  src_t          src_q;
  logic          rst_q, osc_q;

  always_comb begin
    unique case (sel_i)
      SRC_CORE_POR: load_val = CW'(CORE_DLY);
      SRC_FINE_POR: load_val = CW'(FINE_DLY);
      SRC_PIN:      load_val = CW'(PIN_DLY);
      default:      load_val = CW'(WDOG_DLY);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(CORE_DLY);
      src_q <= SRC_CORE_POR;
      rst_q <= 1'b1;
      osc_q <= 1'b0;
    end else if (act_i) begin
      cnt_q <= load_val;
      src_q <= sel_i;
      rst_q <= 1'b1;
      osc_q <= (sel_i == SRC_WDOG);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      rst_q <= 1'b1;
      osc_q <= 1'b1;
    end else begin
      rst_q <= 1'b0;
      osc_q <= 1'b1;
    end
  end

  assign rst_req_o  = rst_q;
  assign osc_en_o   = osc_q;
  assign trim_clr_o = rst_q & (src_q != SRC_FINE_POR);
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
  import rstseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  src_t sel_i,
  input  logic ram_off_set_i,
  output logic por_o,
  output logic wdog_o,
  output logic ram_off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_o     <= 1'b1;
      wdog_o    <= 1'b0;
      ram_off_o <= 1'b0;
    end else if (act_i && sel_i == SRC_WDOG) begin
      por_o  <= 1'b0;
      wdog_o <= 1'b1;
    end else if (act_i) begin
      por_o     <= 1'b1;
      wdog_o    <= 1'b0;
      ram_off_o <= 1'b0;
    end else if (ram_off_set_i) begin
      ram_off_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  output logic rst_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = sh_q[STAGES-1];
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int CORE_DLY    = 512,
  parameter int FINE_DLY    = 1,
  parameter int PIN_DLY     = 8,
  parameter int WDOG_DLY    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_slow_i,
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_por_i,
  input  logic fine_por_i,
  input  logic pin_rst_i,
  input  logic wdog_i,
  input  logic ram_off_set_i,
  output logic cpu_rst_o,
  output logic osc_en_o,
  output logic trim_clr_o,
  output logic stat_por_o,
  output logic stat_wdog_o,
  output logic stat_ram_off_o
);
  logic [NUM_SRC-1:0] req;
  logic               act;
  src_t               sel;
  logic               slow_rst;

  rstseq_src_cond u_cond (
    .clk_i      (clk_slow_i),
    .rst_ni     (rst_ni),
    .core_por_i (core_por_i),
    .fine_por_i (fine_por_i),
    .pin_rst_i  (pin_rst_i),
    .wdog_i     (wdog_i),
    .req_o      (req)
  );

  rstseq_arbiter u_arb (
    .req_i (req),
    .act_o (act),
    .sel_o (sel)
  );

  rstseq_timer #(
    .CORE_DLY (CORE_DLY),
    .FINE_DLY (FINE_DLY),
    .PIN_DLY  (PIN_DLY),
    .WDOG_DLY (WDOG_DLY)
  ) u_tmr (
    .clk_i      (clk_slow_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .sel_i      (sel),
    .rst_req_o  (slow_rst),
    .osc_en_o   (osc_en_o),
    .trim_clr_o (trim_clr_o)
  );

  rstseq_status u_stat (
    .clk_i         (clk_slow_i),
    .rst_ni        (rst_ni),
    .act_i         (act),
    .sel_i         (sel),
    .ram_off_set_i (ram_off_set_i),
    .por_o         (stat_por_o),
    .wdog_o        (stat_wdog_o),
    .ram_off_o     (stat_ram_off_o)
  );

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .arst_i (slow_rst),
    .rst_o  (cpu_rst_o)
  );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic clk_slow_i,
  input logic clk_i,
  input logic rst_ni,
  input logic core_por_i,
  input logic fine_por_i,
  input logic pin_rst_i,
  input logic slow_rst,
  input logic cpu_rst_o,
  input logic osc_en_o,
  input logic trim_clr_o,
  input logic stat_por_o,
  input logic stat_wdog_o,
  input logic stat_ram_off_o
);
  assert_osc_off_R8: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    (core_por_i || pin_rst_i) |=> !osc_en_o);

  assert_osc_before_release_R8: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    (!slow_rst && $past(slow_rst)) |-> $past(osc_en_o));

  assert_fine_no_trim_R3: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    (fine_por_i && !core_por_i) |=> !trim_clr_o);

  assert_por_flags_R6: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    (core_por_i || pin_rst_i) |=> (stat_por_o && !stat_wdog_o && !stat_ram_off_o));

  assert_async_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_rst |-> cpu_rst_o);

  assert_sync_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> !slow_rst);
endmodule

bind reset_sequencer rstseq_checker u_chk (
  .clk_slow_i     (clk_slow_i),
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .core_por_i     (core_por_i),
  .fine_por_i     (fine_por_i),
  .pin_rst_i      (pin_rst_i),
  .slow_rst       (slow_rst),
  .cpu_rst_o      (cpu_rst_o),
  .osc_en_o       (osc_en_o),
  .trim_clr_o     (trim_clr_o),
  .stat_por_o     (stat_por_o),
  .stat_wdog_o    (stat_wdog_o),
  .stat_ram_off_o (stat_ram_off_o)
);

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;
  logic clk_i = 1'b0, clk_slow_i = 1'b0, rst_ni = 1'b0;
  logic core_por_i = 1'b1, fine_por_i = 1'b0, pin_rst_i = 1'b0;
  logic wdog_i = 1'b0, ram_off_set_i = 1'b0;
  logic cpu_rst_o, osc_en_o, trim_clr_o, stat_por_o, stat_wdog_o, stat_ram_off_o;

  int n_chk = 0, n_bad = 0;
  int    exp_q[$];
  string tag_q[$];

  always #4  clk_i = ~clk_i;       // 125 MHz
  always #40 clk_slow_i = ~clk_slow_i;

  reset_sequencer u_reset_sequencer (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side: queue the expected release edge count
  task automatic expect_release(string req, int edges);
    exp_q.push_back(edges);
    tag_q.push_back(req);
  endtask

  // monitor side: count slow edges until cpu_rst_o falls, compare with queue head
  task automatic measure();
    int n = 0;
    int e = exp_q.pop_front();
    string t = tag_q.pop_front();
    do begin
      @(posedge clk_slow_i); n++;
      @(negedge clk_slow_i);
    end while (cpu_rst_o && n < 1000);
    check(t, n, e);
  endtask

  task automatic slow_cycles(int k);
    repeat (k) @(negedge clk_slow_i);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    slow_cycles(3);
    rst_ni = 1'b1;
    slow_cycles(2);
    check("R6 reset cpu_rst", cpu_rst_o, 1);
    check("R8 reset osc off", osc_en_o, 0);
    check("R6 reset stat_por", stat_por_o, 1);
    check("R11 trim during core por", trim_clr_o, 1);

    // R2 core power-on delay
    expect_release("R2 core por release edge", 513);
    core_por_i = 1'b0;
    measure();
    check("R8 osc on after release", osc_en_o, 1);

    // R4 pin reset, osc gating, trim, flags
    slow_cycles(2);
    pin_rst_i = 1'b1;
    slow_cycles(3);
    check("R8 osc off during pin", osc_en_o, 0);
    check("R11 trim during pin", trim_clr_o, 1);
    check("R6 pin stat_por", stat_por_o, 1);
    expect_release("R4 pin release edge", 9);
    pin_rst_i = 1'b0;
    measure();

    // R3 fine power-on: stretch + delay, no trim clear
    slow_cycles(2);
    fine_por_i = 1'b1;
    slow_cycles(3);
    check("R3 no trim on fine por", trim_clr_o, 0);
    check("R8 osc off during fine por", osc_en_o, 0);
    expect_release("R3 fine por release edge", 3);
    fine_por_i = 1'b0;
    measure();

    // R7 ram-off flag set, then watchdog keeps it
    slow_cycles(2);
    ram_off_set_i = 1'b1;
    slow_cycles(1);
    ram_off_set_i = 1'b0;
    check("R7 ram_off set", stat_ram_off_o, 1);
    expect_release("R5 wdog release edge", 3);
    wdog_i = 1'b1;
    @(posedge clk_slow_i); #2;
    check("R9 async assert", cpu_rst_o, 1);
    @(negedge clk_slow_i);
    check("R8 osc on during wdog", osc_en_o, 1);
    check("R11 trim during wdog", trim_clr_o, 1);
    check("R7 wdog stat_por", stat_por_o, 0);
    check("R7 wdog stat_wdog", stat_wdog_o, 1);
    check("R7 ram_off kept", stat_ram_off_o, 1);
    // measure counts from the next edge; one edge already elapsed
    exp_q[0] = 2;
    measure();
    slow_cycles(5);
    check("R5 held wdog no retrigger", cpu_rst_o, 0);
    wdog_i = 1'b0;

    // R6 pin reset clears watchdog flags
    slow_cycles(2);
    pin_rst_i = 1'b1;
    slow_cycles(2);
    check("R6 pin clears stat_wdog", stat_wdog_o, 0);
    check("R6 pin clears ram_off", stat_ram_off_o, 0);
    pin_rst_i = 1'b0;
    // R9 sync release timing: request falls on slow edge 9
    repeat (9) @(posedge clk_slow_i);
    #6;
    check("R9 held after first cpu edge", cpu_rst_o, 1);
    #8;
    check("R9 released at second cpu edge", cpu_rst_o, 0);

    // R1 priority: fine por outranks pin when both drop together
    slow_cycles(2);
    fine_por_i = 1'b1; pin_rst_i = 1'b1;
    slow_cycles(3);
    check("R1 fine por wins trim", trim_clr_o, 0);
    expect_release("R1 priority release edge", 3);
    fine_por_i = 1'b0; pin_rst_i = 1'b0;
    measure();

    // R10 restart: watchdog mid pin count gives short delay
    slow_cycles(2);
    pin_rst_i = 1'b1;
    slow_cycles(2);
    expect_release("R10 restart release edge", 6);
    pin_rst_i = 1'b0;
    fork
      measure();
      begin
        repeat (3) @(posedge clk_slow_i);
        @(negedge clk_slow_i);
        wdog_i = 1'b1;
      end
    join
    check("R10 restart stat_wdog", stat_wdog_o, 1);
    wdog_i = 1'b0;

    slow_cycles(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule